// File: doc/BRIEF.md
# Codec Register Access Port

This block gives a host a single 32-bit command and status word for reaching the register space of an external audio codec. The host writes one word that carries a 7-bit register index, a read or write choice, a primary or secondary codec select, 16 bits of write data and a go flag. Once the port accepts the word, it raises busy, presents the transaction on a request/acknowledge interface toward the codec, and drops busy when the codec acknowledges. For a read, the returned 16-bit value appears in the upper half of the same status word in the cycle busy clears.

The host is expected to poll busy with a bounded number of attempts before it issues the next command. If it does not wait, the port drops the new command and records a sticky overrun flag. If the codec never acknowledges, a timer with a limit set at a port aborts the transaction and records a sticky timeout flag, so that polling always ends. The serial link framing to the codec lies outside the block: the codec side is a plain request held until acknowledged.

Word layout (both directions): bits 6:0 register index, bit 7 ignored (reads 0), bit 8 secondary codec select, bit 9 go on write / busy on read, bit 10 write (1) or read (0), bit 11 overrun flag, bit 12 timeout flag, bits 15:13 zero, bits 31:16 data.

Top module: `cxp_codec_port`

## Requirements
- R1: After reset the status word reads all zero and the codec request is low.
- R2: A host write with bit 9 set while idle starts a transaction: from the next cycle busy (bit 9) and the codec request are high, and the request carries index = bits 6:0 (bit 7 has no effect), secondary select = bit 8, write = bit 10 and write data = bits 31:16.
- R3: Busy and the request stay high, with request fields unchanged, until the first cycle in which the codec acknowledge is high; at that clock edge both fall, so busy lasts exactly as many cycles as the codec takes to acknowledge.
- R4: When a read completes, bits 31:16 of the status word hold the codec's returned data in the same cycle busy reads low.
- R5: When a write completes, bits 31:16 keep the written data; the codec's returned data is ignored.
- R6: A host write with bit 9 set while busy is dropped: the request fields do not change, and bit 11 (overrun) is set and stays set.
- R7: If no acknowledge arrives, the request stays high for exactly `ack_limit` cycles (a limit of 0 acts as 1), then busy and the request fall and bit 12 (timeout) is set.
- R8: Any host write while idle clears bits 11 and 12; a write with bit 9 clear while idle changes nothing else and starts no transaction.
- R9: An acknowledge while no request is pending has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 32 | Command word written by the host |
| host_status | output | 32 | Status word read by the host |
| ack_limit | input | TMO_W | Cycles the request may stay unanswered before abort |
| cdc_req | output | 1 | Transaction request to the codec, held until acknowledged |
| cdc_write | output | 1 | Request is a write (1) or a read (0) |
| cdc_sec | output | 1 | Request targets the secondary codec |
| cdc_index | output | 7 | Codec register index |
| cdc_wdata | output | 16 | Data for a codec write |
| cdc_ack | input | 1 | Codec acknowledge, one cycle |
| cdc_rdata | input | 16 | Codec read data, valid with the acknowledge |

## Verification
The bench builds the block with an 8-bit timeout counter and drives `ack_limit` at 40 for normal traffic and 5 for the abort case, so an unanswered request reaches its limit within a few cycles while codec latencies of one to six cycles still complete. Those short limits make the exact length of the request window, the overrun on a command issued mid-transaction and the flag clearing all reachable in a short run, with primary and secondary register sets kept apart in the codec model.

// File: rtl/cxp_pkg.sv
package cxp_pkg;
   localparam int unsigned IDX_W    = 7;
   localparam int unsigned DATA_W   = 16;
   localparam int unsigned B_SEC    = 8;
   localparam int unsigned B_GO     = 9;
   localparam int unsigned B_WR     = 10;
   localparam int unsigned B_OVR    = 11;
   localparam int unsigned B_TMO    = 12;
   localparam int unsigned DATA_LSB = 16;

   typedef struct packed {
      logic              go;
      logic              wr;
      logic              sec;
      logic [IDX_W-1:0]  idx;
      logic [DATA_W-1:0] data;
   } cmd_t;

   typedef enum logic {S_IDLE = 1'b0, S_WAIT = 1'b1} seq_st_t;
endpackage

// File: rtl/cxp_cmd_decode.sv
module cxp_cmd_decode
   import cxp_pkg::*;
#(
   parameter int unsigned WORD_W = 32
) (
   input  logic [WORD_W-1:0] word,
   output cmd_t              cmd
);
   initial begin
      if (WORD_W != DATA_LSB + DATA_W)
         $error("cxp_cmd_decode: WORD_W must equal %0d", DATA_LSB + DATA_W);
   end

   always_comb begin
      cmd.go   = word[B_GO];
      cmd.wr   = word[B_WR];
      cmd.sec  = word[B_SEC];
      cmd.idx  = word[IDX_W-1:0];
      cmd.data = word[DATA_LSB +: DATA_W];
   end

   logic unused_bits;
   assign unused_bits = ^{word[IDX_W], word[DATA_LSB-1:B_OVR]};
endmodule

// File: rtl/cxp_ack_timer.sv
module cxp_ack_timer #(
   parameter int unsigned TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [TMO_W-1:0] limit,
   output logic             expire
);
   localparam int unsigned CW = TMO_W + 1;

   initial begin
      if (TMO_W < 2) $error("cxp_ack_timer: TMO_W must be at least 2");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nx;

   assign cnt_nx = cnt + CW'(1);
   assign expire = run && (cnt_nx >= {1'b0, limit});

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (start)  cnt <= '0;
      else if (run && !expire) cnt <= cnt_nx;
   end
endmodule

// File: rtl/cxp_seq.sv
module cxp_seq
   import cxp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  cmd_t              cmd,
   input  logic              cdc_ack,
   input  logic [DATA_W-1:0] cdc_rdata,
   input  logic              expire,
   output logic              start,
   output logic              waiting,
   output logic              q_wr,
   output logic              q_sec,
   output logic [IDX_W-1:0]  q_idx,
   output logic [DATA_W-1:0] q_data,
   output logic              q_ovr,
   output logic              q_tmo
);
   seq_st_t st;

   assign waiting = (st == S_WAIT);
   assign start   = (st == S_IDLE) && host_we && cmd.go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         q_wr   <= 1'b0;
         q_sec  <= 1'b0;
         q_idx  <= '0;
         q_data <= '0;
         q_ovr  <= 1'b0;
         q_tmo  <= 1'b0;
      end else if (st == S_IDLE) begin
         if (host_we) begin
            q_ovr <= 1'b0;
            q_tmo <= 1'b0;
            if (cmd.go) begin
               st     <= S_WAIT;
               q_wr   <= cmd.wr;
               q_sec  <= cmd.sec;
               q_idx  <= cmd.idx;
               q_data <= cmd.data;
            end
         end
      end else begin
         if (host_we && cmd.go) q_ovr <= 1'b1;
         if (cdc_ack) begin
            st <= S_IDLE;
            if (!q_wr) q_data <= cdc_rdata;
         end else if (expire) begin
            st    <= S_IDLE;
            q_tmo <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cxp_codec_port.sv
module cxp_codec_port
   import cxp_pkg::*;
#(
   parameter int unsigned TMO_W  = 16,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [WORD_W-1:0] host_wdata,
   output logic [WORD_W-1:0] host_status,
   input  logic [TMO_W-1:0]  ack_limit,
   output logic              cdc_req,
   output logic              cdc_write,
   output logic              cdc_sec,
   output logic [IDX_W-1:0]  cdc_index,
   output logic [DATA_W-1:0] cdc_wdata,
   input  logic              cdc_ack,
   input  logic [DATA_W-1:0] cdc_rdata
);
   cmd_t              cmd;
   logic              start, waiting, expire;
   logic              q_wr, q_sec, q_ovr, q_tmo;
   logic [IDX_W-1:0]  q_idx;
   logic [DATA_W-1:0] q_data;

   cxp_cmd_decode #(.WORD_W(WORD_W)) u_dec (
      .word (host_wdata),
      .cmd  (cmd)
   );

   cxp_ack_timer #(.TMO_W(TMO_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .run    (waiting),
      .limit  (ack_limit),
      .expire (expire)
   );

   cxp_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_we),
      .cmd       (cmd),
      .cdc_ack   (cdc_ack),
      .cdc_rdata (cdc_rdata),
      .expire    (expire),
      .start     (start),
      .waiting   (waiting),
      .q_wr      (q_wr),
      .q_sec     (q_sec),
      .q_idx     (q_idx),
      .q_data    (q_data),
      .q_ovr     (q_ovr),
      .q_tmo     (q_tmo)
   );

   assign cdc_req   = waiting;
   assign cdc_write = q_wr;
   assign cdc_sec   = q_sec;
   assign cdc_index = q_idx;
   assign cdc_wdata = q_data;

   always_comb begin
      host_status                      = '0;
      host_status[IDX_W-1:0]           = q_idx;
      host_status[B_SEC]               = q_sec;
      host_status[B_GO]                = waiting;
      host_status[B_WR]                = q_wr;
      host_status[B_OVR]               = q_ovr;
      host_status[B_TMO]               = q_tmo;
      host_status[DATA_LSB +: DATA_W]  = q_data;
   end
endmodule

// File: rtl/cxp_codec_port_chk.sv
module cxp_codec_port_chk
   import cxp_pkg::*;
#(
   parameter int unsigned TMO_W  = 16,
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_we,
   input logic [WORD_W-1:0] host_wdata,
   input logic [WORD_W-1:0] host_status,
   input logic [TMO_W-1:0]  ack_limit,
   input logic              cdc_req,
   input logic              cdc_write,
   input logic [IDX_W-1:0]  cdc_index,
   input logic [DATA_W-1:0] cdc_wdata,
   input logic              cdc_ack,
   input logic [DATA_W-1:0] cdc_rdata
);
   logic [TMO_W:0] run_len;
   logic [TMO_W:0] eff_lim;

   assign eff_lim = (ack_limit == '0) ? (TMO_W+1)'(1) : {1'b0, ack_limit};

   always_ff @(posedge clk) begin
      if (!rst_n)       run_len <= '0;
      else if (cdc_req) run_len <= run_len + 1'b1;
      else              run_len <= '0;
   end

   a_r2_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!cdc_req && host_we && host_wdata[B_GO]) |=> (cdc_req && host_status[B_GO]));

   a_r3_ack_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_req && cdc_ack) |=> (!cdc_req && !host_status[B_GO]));

   a_r6_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_req && !cdc_ack) |=> (!cdc_req || ($stable(cdc_index) && $stable(cdc_wdata) && $stable(cdc_write))));

   a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_req && host_we && host_wdata[B_GO]) |=> host_status[B_OVR]);

   a_r4_read_data: assert property (@(posedge clk) disable iff (!rst_n)
      (cdc_req && cdc_ack && !cdc_write) |=> (host_status[DATA_LSB +: DATA_W] == $past(cdc_rdata)));

   a_r7_req_window: assert property (@(posedge clk) disable iff (!rst_n)
      cdc_req |-> (run_len < eff_lim));
endmodule

bind cxp_codec_port cxp_codec_port_chk #(.TMO_W(TMO_W), .WORD_W(WORD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_we     (host_we),
   .host_wdata  (host_wdata),
   .host_status (host_status),
   .ack_limit   (ack_limit),
   .cdc_req     (cdc_req),
   .cdc_write   (cdc_write),
   .cdc_index   (cdc_index),
   .cdc_wdata   (cdc_wdata),
   .cdc_ack     (cdc_ack),
   .cdc_rdata   (cdc_rdata)
);

// File: tb/tb_cxp_codec_port.sv
module tb_cxp_codec_port;
   localparam int TMO_W  = 8;
   localparam int POLL   = 65535;
   localparam int WDOG   = 200000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_status;
   logic [TMO_W-1:0] ack_limit = 8'd40;
   logic        cdc_req, cdc_write, cdc_sec;
   logic [6:0]  cdc_index;
   logic [15:0] cdc_wdata;
   logic        cdc_ack = 1'b0;
   logic [15:0] cdc_rdata = '0;

   int checks = 0;
   int fails  = 0;
   int lat    = 1;
   bit manual = 1'b0;
   bit done   = 1'b0;

   logic [15:0] dev_mem [0:1][0:127];
   logic [15:0] ref_mem [0:1][0:127];
   logic [31:0] exp_q [$];

   cxp_codec_port #(.TMO_W(TMO_W)) dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
      .host_status(host_status), .ack_limit(ack_limit), .cdc_req(cdc_req),
      .cdc_write(cdc_write), .cdc_sec(cdc_sec), .cdc_index(cdc_index),
      .cdc_wdata(cdc_wdata), .cdc_ack(cdc_ack), .cdc_rdata(cdc_rdata)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [15:0] d, input logic [6:0] i,
                                      input logic s, input logic w, input logic o, input logic t);
      return {d, 3'b000, t, o, w, 1'b0, s, 1'b0, i};
   endfunction

   function automatic logic [31:0] cmdw(input logic [15:0] d, input logic [6:0] i,
                                        input logic s, input logic w, input logic go, input logic b7);
      return {d, 5'b00000, w, go, s, b7, i};
   endfunction

   // codec model
   initial begin
      int waitc = 0;
      forever begin
         @(negedge clk);
         if (!manual) begin
            cdc_ack = 1'b0;
            if (cdc_req && lat > 0) begin
               waitc++;
               if (waitc >= lat) begin
                  cdc_ack = 1'b1;
                  if (cdc_write) begin
                     dev_mem[cdc_sec][cdc_index] = cdc_wdata;
                     cdc_rdata = 16'hDEAD;
                  end else begin
                     cdc_rdata = dev_mem[cdc_sec][cdc_index];
                  end
                  waitc = 0;
               end
            end else begin
               waitc = 0;
            end
         end
      end
   end

   // scoreboard monitor
   initial begin
      logic prev_busy = 1'b0;
      forever begin
         @(negedge clk);
         if (rst_n && prev_busy && !host_status[9]) begin
            if (exp_q.size() == 0) check("R4 R5 unexpected completion", host_status, 32'hFFFF_FFFF);
            else check("R4 R5 R7 completion word", host_status, exp_q.pop_front());
         end
         prev_busy = rst_n ? host_status[9] : 1'b0;
      end
   end

   initial begin
      #(WDOG * 20);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   task automatic issue(input logic [31:0] w);
      @(negedge clk);
      host_we = 1'b1; host_wdata = w;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic poll(input string tag, output int n);
      n = 0;
      while (host_status[9] && n < POLL) begin
         n++;
         @(negedge clk);
      end
      if (n >= POLL) check({tag, " poll budget"}, 1, 0);
   endtask

   task automatic xact(input logic s, input logic w, input logic [6:0] i,
                       input logic [15:0] d, input int l, input logic b7);
      int n;
      lat = l;
      exp_q.push_back(mk(w ? d : ref_mem[s][i], i, s, w, 1'b0, 1'b0));
      if (w) ref_mem[s][i] = d;
      issue(cmdw(d, i, s, w, 1'b1, b7));
      check("R2 request fields", {cdc_req, cdc_write, cdc_sec, cdc_index, cdc_wdata},
            {1'b1, w, s, i, d});
      check("R2 busy set", {31'd0, host_status[9]}, 32'd1);
      poll("R3", n);
      check("R3 busy cycles", n, l);
      @(negedge clk);
   endtask

   initial begin
      int n;
      logic [31:0] snap;
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 128; i++) begin
            dev_mem[s][i] = 16'(s * 16'h4000 + i * 16'h0101);
            ref_mem[s][i] = 16'(s * 16'h4000 + i * 16'h0101);
         end
      repeat (3) @(negedge clk);
      check("R1 reset status", host_status, 32'h0);
      check("R1 reset request", {31'd0, cdc_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R5 writes, R4 reads, across both codecs
      xact(1'b0, 1'b1, 7'h05, 16'hA5A5, 3, 1'b0);
      xact(1'b0, 1'b0, 7'h05, 16'h0000, 1, 1'b0);
      xact(1'b1, 1'b1, 7'h05, 16'h1234, 2, 1'b0);
      xact(1'b0, 1'b0, 7'h05, 16'hFFFF, 4, 1'b0);
      xact(1'b1, 1'b0, 7'h05, 16'h0000, 6, 1'b0);
      xact(1'b1, 1'b0, 7'h7F, 16'h0000, 2, 1'b0);
      // R2 bit 7 ignored
      xact(1'b0, 1'b0, 7'h0A, 16'h0000, 1, 1'b1);

      // R6 overrun
      lat = 6;
      exp_q.push_back(mk(ref_mem[0][3], 7'h03, 1'b0, 1'b0, 1'b1, 1'b0));
      issue(cmdw(16'h0000, 7'h03, 1'b0, 1'b0, 1'b1, 1'b0));
      issue(cmdw(16'h5555, 7'h44, 1'b1, 1'b1, 1'b1, 1'b0));
      check("R6 fields unchanged", {cdc_req, cdc_write, cdc_sec, cdc_index, cdc_wdata},
            {1'b1, 1'b0, 1'b0, 7'h03, 16'h0000});
      check("R6 overrun flag", {31'd0, host_status[11]}, 32'd1);
      poll("R6", n);
      @(negedge clk);
      check("R6 overrun sticky", {31'd0, host_status[11]}, 32'd1);
      check("R6 dropped write not performed", {16'd0, dev_mem[1][7'h44]}, {16'd0, ref_mem[1][7'h44]});

      // R8 clear with go low
      snap = host_status;
      issue(cmdw(16'h7777, 7'h11, 1'b1, 1'b1, 1'b0, 1'b0));
      check("R8 flags cleared, rest kept", host_status, snap & ~32'h0000_1800);
      check("R8 no request", {31'd0, cdc_req}, 32'd0);

      // R7 timeout
      lat = 0;
      ack_limit = 8'd5;
      exp_q.push_back(mk(16'h0BAD, 7'h21, 1'b1, 1'b0, 1'b0, 1'b1));
      issue(cmdw(16'h0BAD, 7'h21, 1'b1, 1'b0, 1'b1, 1'b0));
      poll("R7", n);
      check("R7 request window", n, 5);
      check("R7 timeout flag", {31'd0, host_status[12]}, 32'd1);
      check("R7 request low", {31'd0, cdc_req}, 32'd0);
      @(negedge clk);
      ack_limit = 8'd40;

      // R8 accepted command clears timeout
      xact(1'b0, 1'b1, 7'h30, 16'hC0DE, 2, 1'b0);
      check("R8 timeout cleared", {30'd0, host_status[12:11]}, 32'd0);

      // R9 stray acknowledge
      snap = host_status;
      manual = 1'b1;
      @(negedge clk);
      cdc_ack = 1'b1; cdc_rdata = 16'hBEEF;
      @(negedge clk);
      cdc_ack = 1'b0;
      @(negedge clk);
      manual = 1'b0;
      check("R9 stray ack ignored", host_status, snap);

      xact(1'b0, 1'b0, 7'h30, 16'h0000, 1, 1'b0);
      check("R4 R5 scoreboard drained", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule